// File: doc/BRIEF.md
# Memory Cycle Pulse Sequencer

This block turns a single access strobe, issued by an upstream arbiter, into the ordered control pulses that one cycle of a single-port static memory array needs. The pulses are bit-line precharge (active low), bit-line equalise, write-drive enable, word-line select and read-data latch. A read and a write follow different pulse sequences. A read precharges the bit lines, raises the word line and then latches the single-ended data. A write never precharges. It equalises the bit lines, then turns on the one-sided write driver, and only after that raises a word line that is shorter than the read word line. This keeps bit-line charging on the unselected columns to a minimum.

Each phase length is a parameter counted in clock cycles. A single down-counter times the phase that is current. A one-cycle completion pulse goes back to the arbiter. The `busy` output tells the arbiter when a new strobe can be accepted.

States: `ST_IDLE`, `ST_RD_PCH`, `ST_RD_WL`, `ST_RD_LAT`, `ST_WR_EQ`, `ST_WR_DRV`, `ST_WR_WL`, `ST_DONE`. Transitions:
- `ST_IDLE` → `ST_RD_PCH` on a strobe with `acc_wr_i`=0.
- `ST_IDLE` → `ST_WR_EQ` on a strobe with `acc_wr_i`=1.
- `ST_RD_PCH` → `ST_RD_WL` → `ST_RD_LAT` → `ST_DONE`, each move taken when the phase timer expires.
- `ST_WR_EQ` → `ST_WR_DRV` when the timer expires.
- `ST_WR_DRV` → `ST_WR_WL` unconditionally after one cycle.
- `ST_WR_WL` → `ST_DONE` when the timer expires.
- `ST_DONE` → `ST_IDLE` unconditionally.

Top module: `mem_cycle_seq`

## Requirements
- R1: After reset, `pch_n_o`=1 and `eq_o`, `wdrv_o`, `wl_o`, `lat_o`, `done_o` and `busy_o` are all 0.
- R2: A strobe sampled high while idle, with `acc_wr_i`=0, starts a read on the next cycle. The read begins with `pch_n_o`=0 for exactly P_PCH cycles.
- R3: In a read, `wl_o` is high for exactly P_WL_RD cycles, starting the cycle after precharge ends. `pch_n_o`=0 and `wl_o`=1 never occur together.
- R4: In a read, `lat_o` is high for exactly P_LAT cycles, starting the cycle after the word line drops.
- R5: In a write (strobe with `acc_wr_i`=1), `pch_n_o` stays 1 for the whole cycle.
- R6: A write begins with `eq_o` high for exactly P_EQ cycles. `wdrv_o` then rises alone for one cycle before `wl_o` rises.
- R7: In a write, `wl_o` is high for exactly P_WL_WR cycles while `wdrv_o` stays high, and both drop together. With the default parameters, P_WL_WR (1) is shorter than P_WL_RD (3).
- R8: `done_o` is high for exactly one cycle. That cycle is the first one in which all five control outputs are inactive after the last phase.
- R9: `busy_o` is high from the cycle after the accepted strobe through the `done_o` cycle inclusive.
- R10: Strobes are ignored while `busy_o` is high. At least one idle cycle (`busy_o`=0) follows every `done_o` before the next access begins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_stb_i | input | 1 | Access strobe from the arbiter |
| acc_wr_i | input | 1 | Access kind sampled with the strobe: 1 write, 0 read |
| busy_o | output | 1 | Cycle in progress |
| pch_n_o | output | 1 | Bit-line precharge, active low |
| eq_o | output | 1 | Bit-line equalise |
| wdrv_o | output | 1 | Write-drive enable |
| wl_o | output | 1 | Word-line select |
| lat_o | output | 1 | Read-data latch enable |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The hardest situation to reach is a strobe that arrives during the `ST_DONE` cycle, or in the one idle cycle right after it. An arbiter that keeps its request asserted produces exactly this case. It tests both the ignore rule and the minimum gap between accesses. The stimulus holds the strobe high for long directed stretches and also draws random strobes with short gaps. A cycle-level reference model in the bench predicts which cycle is accepted, and it checks every control output on every cycle against the phase lengths.

// File: rtl/mem_cycle_pkg.sv
package mem_cycle_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_PCH,
        ST_RD_WL,
        ST_RD_LAT,
        ST_WR_EQ,
        ST_WR_DRV,
        ST_WR_WL,
        ST_DONE
    } seq_state_t;

    typedef struct packed {
        logic busy;
        logic pch_n;
        logic eq;
        logic wdrv;
        logic wl;
        logic lat;
        logic done;
    } seq_ctrl_t;

    function automatic int unsigned max_len(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/mem_cycle_timer.sv
module mem_cycle_timer #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/mem_cycle_decode.sv
module mem_cycle_decode
    import mem_cycle_pkg::*;
(
    input  seq_state_t state,
    output seq_ctrl_t  ctrl
);
    always_comb begin
        ctrl       = '0;
        ctrl.pch_n = 1'b1;
        ctrl.busy  = (state != ST_IDLE);
        unique case (state)
            ST_IDLE:   ;
            ST_RD_PCH: ctrl.pch_n = 1'b0;
            ST_RD_WL:  ctrl.wl    = 1'b1;
            ST_RD_LAT: ctrl.lat   = 1'b1;
            ST_WR_EQ:  ctrl.eq    = 1'b1;
            ST_WR_DRV: ctrl.wdrv  = 1'b1;
            ST_WR_WL: begin
                ctrl.wdrv = 1'b1;
                ctrl.wl   = 1'b1;
            end
            ST_DONE:   ctrl.done  = 1'b1;
            default:   ;
        endcase
    end
endmodule

// File: rtl/mem_cycle_seq.sv
module mem_cycle_seq
    import mem_cycle_pkg::*;
#(
    parameter int P_PCH   = 2,
    parameter int P_EQ    = 2,
    parameter int P_WL_RD = 3,
    parameter int P_WL_WR = 1,
    parameter int P_LAT   = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic acc_stb_i,
    input  logic acc_wr_i,
    output logic busy_o,
    output logic pch_n_o,
    output logic eq_o,
    output logic wdrv_o,
    output logic wl_o,
    output logic lat_o,
    output logic done_o
);
    localparam int unsigned LONGEST =
        max_len(max_len(max_len(P_PCH, P_EQ), max_len(P_WL_RD, P_WL_WR)), P_LAT);
    localparam int CW = $clog2(LONGEST + 1) + 1;

    seq_state_t    state_q, state_d;
    logic          tmr_load;
    logic [CW-1:0] tmr_val;
    logic          tmr_exp;
    seq_ctrl_t     ctrl;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state_q)
            ST_IDLE: if (acc_stb_i) begin
                tmr_load = 1'b1;
                if (acc_wr_i) begin
                    state_d = ST_WR_EQ;
                    tmr_val = CW'(P_EQ - 1);
                end else begin
                    state_d = ST_RD_PCH;
                    tmr_val = CW'(P_PCH - 1);
                end
            end
            ST_RD_PCH: if (tmr_exp) begin
                state_d  = ST_RD_WL;
                tmr_load = 1'b1;
                tmr_val  = CW'(P_WL_RD - 1);
            end
            ST_RD_WL: if (tmr_exp) begin
                state_d  = ST_RD_LAT;
                tmr_load = 1'b1;
                tmr_val  = CW'(P_LAT - 1);
            end
            ST_RD_LAT: if (tmr_exp) state_d = ST_DONE;
            ST_WR_EQ:  if (tmr_exp) state_d = ST_WR_DRV;
            ST_WR_DRV: begin
                state_d  = ST_WR_WL;
                tmr_load = 1'b1;
                tmr_val  = CW'(P_WL_WR - 1);
            end
            ST_WR_WL:  if (tmr_exp) state_d = ST_DONE;
            ST_DONE:   state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    mem_cycle_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_exp)
    );

    mem_cycle_decode u_dec (
        .state (state_q),
        .ctrl  (ctrl)
    );

    assign busy_o  = ctrl.busy;
    assign pch_n_o = ctrl.pch_n;
    assign eq_o    = ctrl.eq;
    assign wdrv_o  = ctrl.wdrv;
    assign wl_o    = ctrl.wl;
    assign lat_o   = ctrl.lat;
    assign done_o  = ctrl.done;
endmodule

// File: rtl/mem_cycle_seq_chk.sv
module mem_cycle_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic acc_stb_i,
    input logic busy_o,
    input logic pch_n_o,
    input logic eq_o,
    input logic wdrv_o,
    input logic wl_o,
    input logic lat_o,
    input logic done_o
);
    AST_PCH_WL_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(!pch_n_o && wl_o)); // R3
    AST_EQ_NO_PCH: assert property (@(posedge clk) disable iff (!rst_n) (eq_o || wdrv_o) |-> pch_n_o); // R5
    AST_WL_AFTER_DRV: assert property (@(posedge clk) disable iff (!rst_n) ($rose(wl_o) && wdrv_o) |-> $past(wdrv_o)); // R6
    AST_DRV_WL_DROP: assert property (@(posedge clk) disable iff (!rst_n) $fell(wdrv_o) |-> $fell(wl_o)); // R7
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) done_o |=> !done_o); // R8
    AST_DONE_CTRL_IDLE: assert property (@(posedge clk) disable iff (!rst_n) done_o |-> (pch_n_o && !eq_o && !wdrv_o && !wl_o && !lat_o)); // R8
    AST_BUSY_FROM_STB: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy_o) |-> $past(acc_stb_i)); // R9
    AST_DONE_BUSY: assert property (@(posedge clk) disable iff (!rst_n) done_o |-> busy_o); // R9
    AST_IDLE_GAP: assert property (@(posedge clk) disable iff (!rst_n) done_o |=> !busy_o); // R10
endmodule

bind mem_cycle_seq mem_cycle_seq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_stb_i (acc_stb_i),
    .busy_o    (busy_o),
    .pch_n_o   (pch_n_o),
    .eq_o      (eq_o),
    .wdrv_o    (wdrv_o),
    .wl_o      (wl_o),
    .lat_o     (lat_o),
    .done_o    (done_o)
);

// File: tb/sim_mem_cycle_seq.sv
module sim_mem_cycle_seq;
    localparam int PCH = 2, EQ = 2, WLR = 3, WLW = 1, LAT = 1;
    localparam int RD_LEN = PCH + WLR + LAT + 1;
    localparam int WR_LEN = EQ + 1 + WLW + 1;

    logic clk = 1'b0, rst_n = 1'b0, stb = 1'b0, wr = 1'b0;
    logic busy, pch_n, eq, wdrv, wl, lat, done;
    int checks = 0, errors = 0;
    bit m_act = 0, m_wr = 0;
    int m_t = 0;

    always #5 clk = ~clk;

    mem_cycle_seq #(.P_PCH(PCH), .P_EQ(EQ), .P_WL_RD(WLR), .P_WL_WR(WLW), .P_LAT(LAT)) u0 (
        .clk(clk), .rst_n(rst_n), .acc_stb_i(stb), .acc_wr_i(wr),
        .busy_o(busy), .pch_n_o(pch_n), .eq_o(eq), .wdrv_o(wdrv),
        .wl_o(wl), .lat_o(lat), .done_o(done)
    );

    // expected vector {busy,pch_n,eq,wdrv,wl,lat,done}
    function automatic logic [6:0] exp_vec(input bit act, input bit w, input int t);
        logic [6:0] v;
        v = 7'b0100000;
        if (!act) return v;
        v[6] = 1'b1;
        if (!w) begin
            if (t < PCH)                  v[5] = 1'b0;
            else if (t < PCH + WLR)       v[2] = 1'b1;
            else if (t < PCH + WLR + LAT) v[1] = 1'b1;
            else                          v[0] = 1'b1;
        end else begin
            if (t < EQ)                   v[4] = 1'b1;
            else if (t == EQ)             v[3] = 1'b1;
            else if (t < EQ + 1 + WLW)    v[3:2] = 2'b11;
            else                          v[0] = 1'b1;
        end
        return v;
    endfunction

    task automatic chk1(input string req, input logic act_v, input logic exp_v, input string nm);
        checks++;
        if (act_v !== exp_v) begin
            errors++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", req, nm, act_v, exp_v, $time);
        end
    endtask

    task automatic check_now();
        logic [6:0] e;
        e = exp_vec(m_act, m_wr, m_t);
        chk1("R9",  busy,  e[6], "busy");
        chk1(m_wr ? "R5" : "R2", pch_n, e[5], "pch_n");
        chk1("R6",  eq,    e[4], "eq");
        chk1("R7",  wdrv,  e[3], "wdrv");
        chk1(m_wr ? "R7" : "R3", wl, e[2], "wl");
        chk1("R4",  lat,   e[1], "lat");
        chk1("R8",  done,  e[0], "done");
    endtask

    // one cycle: check at negedge, drive, advance the model (R10: strobes while busy ignored)
    task automatic cycle(input bit s, input bit w);
        @(negedge clk);
        check_now();
        stb = s; wr = w;
        if (m_act) begin
            if (m_t == (m_wr ? WR_LEN : RD_LEN) - 1) m_act = 0;
            else m_t++;
        end else if (s) begin
            m_act = 1; m_wr = w; m_t = 0;
        end
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk1("R1", busy, 1'b0, "busy");  chk1("R1", pch_n, 1'b1, "pch_n");
        chk1("R1", eq, 1'b0, "eq");      chk1("R1", wdrv, 1'b0, "wdrv");
        chk1("R1", wl, 1'b0, "wl");      chk1("R1", lat, 1'b0, "lat");
        chk1("R1", done, 1'b0, "done");
        rst_n = 1'b1;
        // directed: single read, single write
        cycle(1, 0); repeat (RD_LEN + 2) cycle(0, 0);
        cycle(1, 1); repeat (WR_LEN + 2) cycle(0, 0);
        // directed: strobe held high, alternating kinds (R10 minimum gap)
        for (int i = 0; i < 40; i++) cycle(1, i[3]);
        // directed: strobe toggling kind every cycle during a busy read
        for (int i = 0; i < 20; i++) cycle(1, i[0]);
        // random
        for (int i = 0; i < 3000; i++) cycle(($urandom % 3) != 0, $urandom % 2);
        repeat (RD_LEN + 2) cycle(0, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule